// File: doc/BRIEF.md
# Bit-Serial Adder

The block adds two unsigned operands one bit per clock using a single full-adder cell. Two shift registers hold the operands: the accumulator register and the addend register. Each register presents its least significant bit to the adder. A carry flip-flop feeds the carry of each bit position into the next. Each sum bit enters the accumulator at its top end, so after one pass the accumulator holds the sum in place of its first operand. The addend register rotates, so its value is unchanged at the end of the pass.

Software or a sequencer first loads both operands in parallel, then pulses `start`. The carry is cleared on that edge and a bit counter is armed. Shifting advances only on cycles where `shift_en` is high. After `W` enabled cycles the block drops `busy` and raises `done` for one cycle. The sum is then on `sum_out` and the final carry-out is on `carry_out`. Because the addend survives, a second `start` without a reload adds the same addend again to the new accumulator value.

Top module: `ser_adder`

## Requirements
- R1: After synchronous reset, `sum_out` is 0, `carry_out` is 0, `busy` is 0 and `done` is 0.
- R2: When `load` is high while `busy` is low, `sum_out` equals the sampled `a_in` on the next cycle, and the addend register takes `b_in`.
- R3: A `start` while idle sets `busy` on the next cycle. After exactly `W` cycles with `shift_en` high, `busy` falls and `done` is high for exactly one cycle. In that cycle `sum_out` is (A+B) mod 2^W and `carry_out` is bit `W` of A+B.
- R4: The addend register is preserved by an addition: a second `start` with no reload yields (previous sum + B) mod 2^W.
- R5: `start` clears the carry, so a carry left over from an earlier addition never enters the next sum. `carry_out` is 0 on the cycle after an idle `start`.
- R6: While `busy` is high and `shift_en` is low, `sum_out`, `carry_out` and `busy` hold their values and no bit is consumed.
- R7: `start` while `busy` is ignored: it neither extends nor restarts the addition.
- R8: `load` while `busy` is ignored: the result is computed from the operands present at `start`.
- R9: `shift_en` while idle has no effect on `sum_out`, `carry_out` or `done`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| load | input | 1 | Parallel preload of both operands (idle only) |
| a_in | input | W | Accumulator operand to preload |
| b_in | input | W | Addend operand to preload |
| start | input | 1 | Begin an addition (idle only); clears carry |
| shift_en | input | 1 | Shift control; one bit is processed per high cycle while busy |
| busy | output | 1 | Addition in progress |
| done | output | 1 | One-cycle pulse after the last bit |
| sum_out | output | W | Accumulator contents (the sum after done) |
| carry_out | output | 1 | Carry flip-flop (the final carry after done) |

## Verification
The bench builds the block with its default width of 4. At that width every one of the 256 operand pairs can be run through a full addition. Each pair checks the sum and the final carry against arithmetic, with random stall cycles on `shift_en` in between. The narrow width also makes overflow frequent. Chained additions without reload are therefore likely to start with a stale carry of 1, which exposes a missed carry clear or an addend that was not preserved. Directed passes poke `start` and `load` during a run, and drive `shift_en` while idle.

// File: rtl/ser_add_pkg.sv
package ser_add_pkg;

    typedef enum logic {
        ST_IDLE,
        ST_RUN
    } run_state_e;

    typedef enum logic [1:0] {
        SH_HOLD,
        SH_LOAD,
        SH_RIGHT
    } sh_op_e;

    typedef struct packed {
        logic sum;
        logic carry;
    } fa_res_t;

    function automatic fa_res_t full_add(input logic x, input logic y, input logic z);
        fa_res_t r;
        r.sum   = x ^ y ^ z;
        r.carry = (x & y) | (x & z) | (y & z);
        return r;
    endfunction

endpackage

// File: rtl/ser_shreg.sv
module ser_shreg
    import ser_add_pkg::*;
#(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst,
    input  sh_op_e       op,
    input  logic [W-1:0] pdata,
    input  logic         ser_in,
    output logic [W-1:0] q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            q <= '0;
        end else begin
            case (op)
                SH_LOAD:  q <= pdata;
                SH_RIGHT: q <= {ser_in, q[W-1:1]};
                default:  q <= q;
            endcase
        end
    end
endmodule

// File: rtl/ser_fa_cell.sv
module ser_fa_cell
    import ser_add_pkg::*;
(
    input  logic    x,
    input  logic    y,
    input  logic    z,
    output fa_res_t res
);
    always_comb res = full_add(x, y, z);
endmodule

// File: rtl/ser_carry_ff.sv
module ser_carry_ff (
    input  logic clk,
    input  logic rst,
    input  logic clr,
    input  logic en,
    input  logic d,
    output logic q
);
    always_ff @(posedge clk) begin
        if (rst || clr) q <= 1'b0;
        else if (en)    q <= d;
    end
endmodule

// File: rtl/ser_seq_ctrl.sv
module ser_seq_ctrl
    import ser_add_pkg::*;
#(
    parameter int W = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic start,
    input  logic shift_en,
    output logic busy,
    output logic step,
    output logic kick,
    output logic done
);
    localparam int CW = $clog2(W + 1);
    localparam logic [CW-1:0] CNT_INIT = CW'(W);
    localparam logic [CW-1:0] CNT_LAST = CW'(1);

    run_state_e    state;
    logic [CW-1:0] cnt;

    always_comb begin
        busy = (state == ST_RUN);
        step = busy && shift_en;
        kick = !busy && start;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ST_IDLE;
            cnt   <= '0;
            done  <= 1'b0;
        end else begin
            done <= 1'b0;
            case (state)
                ST_IDLE: begin
                    if (start) begin
                        state <= ST_RUN;
                        cnt   <= CNT_INIT;
                    end
                end
                default: begin
                    if (shift_en) begin
                        cnt <= cnt - 1'b1;
                        if (cnt == CNT_LAST) begin
                            state <= ST_IDLE;
                            done  <= 1'b1;
                        end
                    end
                end
            endcase
        end
    end
endmodule

// File: rtl/ser_adder.sv
module ser_adder
    import ser_add_pkg::*;
#(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic [W-1:0] a_in,
    input  logic [W-1:0] b_in,
    input  logic         start,
    input  logic         shift_en,
    output logic         busy,
    output logic         done,
    output logic [W-1:0] sum_out,
    output logic         carry_out
);
    logic         step, kick, load_ok;
    logic [W-1:0] a_q, b_q;
    sh_op_e       op_a, op_b;
    fa_res_t      fa;

    ser_seq_ctrl #(.W(W)) ctrl_i (
        .clk(clk), .rst(rst), .start(start), .shift_en(shift_en),
        .busy(busy), .step(step), .kick(kick), .done(done)
    );

    always_comb begin
        load_ok = load && !busy;
        if (load_ok)   op_a = SH_LOAD;
        else if (step) op_a = SH_RIGHT;
        else           op_a = SH_HOLD;
        op_b = op_a;
    end

    ser_shreg #(.W(W)) reg_a_i (
        .clk(clk), .rst(rst), .op(op_a), .pdata(a_in), .ser_in(fa.sum), .q(a_q)
    );

    ser_shreg #(.W(W)) reg_b_i (
        .clk(clk), .rst(rst), .op(op_b), .pdata(b_in), .ser_in(b_q[0]), .q(b_q)
    );

    ser_fa_cell fa_i (
        .x(a_q[0]), .y(b_q[0]), .z(carry_out), .res(fa)
    );

    ser_carry_ff cy_i (
        .clk(clk), .rst(rst), .clr(kick), .en(step), .d(fa.carry), .q(carry_out)
    );

    assign sum_out = a_q;
endmodule

// File: rtl/ser_adder_chk.sv
module ser_adder_chk #(
    parameter int W = 4
) (
    input logic         clk,
    input logic         rst,
    input logic         load,
    input logic [W-1:0] a_in,
    input logic         start,
    input logic         shift_en,
    input logic         busy,
    input logic         done,
    input logic [W-1:0] sum_out,
    input logic         carry_out
);
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
        done |=> !done); // R3
    AST_DONE_ENDS_BUSY: assert property (@(posedge clk) disable iff (rst)
        done |-> (!busy && $past(busy))); // R3
    AST_START_ARMS: assert property (@(posedge clk) disable iff (rst)
        (!busy && start) |=> busy); // R3
    AST_START_CLEARS_CARRY: assert property (@(posedge clk) disable iff (rst)
        (!busy && start) |=> !carry_out); // R5
    AST_LOAD_IDLE: assert property (@(posedge clk) disable iff (rst)
        (!busy && load) |=> (sum_out == $past(a_in))); // R2
    AST_STALL_FREEZE: assert property (@(posedge clk) disable iff (rst)
        (busy && !shift_en) |=> ($stable(sum_out) && $stable(carry_out) && busy)); // R6
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
        (!busy && !load && !start) |=> ($stable(sum_out) && $stable(carry_out) && !done)); // R9
endmodule

bind ser_adder ser_adder_chk #(.W(W)) chk_i (
    .clk(clk), .rst(rst), .load(load), .a_in(a_in), .start(start),
    .shift_en(shift_en), .busy(busy), .done(done), .sum_out(sum_out),
    .carry_out(carry_out)
);

// File: tb/ser_adder_tb_top.sv
module ser_adder_tb_top;
    localparam int W = 4;

    logic         clk = 1'b0;
    logic         rst, load, start, shift_en;
    logic [W-1:0] a_in, b_in, sum_out;
    logic         busy, done, carry_out;

    int n_checks = 0;
    int n_errors = 0;
    bit finished = 0;

    logic [W-1:0] m_a, m_b;

    always #10 clk = ~clk;

    ser_adder #(.W(W)) dut_i (
        .clk(clk), .rst(rst), .load(load), .a_in(a_in), .b_in(b_in),
        .start(start), .shift_en(shift_en), .busy(busy), .done(done),
        .sum_out(sum_out), .carry_out(carry_out)
    );

    task automatic chk(input string req, input string what, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    function automatic logic [W:0] ref_add(input logic [W-1:0] a, input logic [W-1:0] b);
        return {1'b0, a} + {1'b0, b};
    endfunction

    task automatic summary();
        if (!finished) begin
            finished = 1;
            $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
            $finish;
        end
    endtask

    // One addition; optional reload, stall percentage, pokes of start/load mid-run.
    task automatic do_add(input logic [W-1:0] a, input logic [W-1:0] b,
                          input bit reload, input int stall_pct, input bit poke);
        logic [W:0]   exp;
        logic [W-1:0] prev;
        logic         prev_c;
        int           en_cnt;
        bit           en;
        if (reload) begin
            load = 1; a_in = a; b_in = b;
            @(negedge clk);
            load = 0;
            chk("R2", "sum_out after load", sum_out, a);
            m_a = a; m_b = b;
        end
        exp = ref_add(m_a, m_b);
        start = 1;
        @(negedge clk);
        start = 0;
        chk("R3", "busy after start", busy, 1);
        chk("R5", "carry cleared at start", carry_out, 0);
        en_cnt = 0;
        while (en_cnt < W) begin
            en = ($urandom % 100) >= stall_pct;
            shift_en = en;
            if (poke) begin
                start = 1; load = 1; a_in = ~m_a; b_in = ~m_b;
            end
            prev = sum_out; prev_c = carry_out;
            @(negedge clk);
            if (en) en_cnt++;
            else begin
                chk("R6", "sum_out stable in stall", sum_out, prev);
                chk("R6", "carry stable in stall", carry_out, prev_c);
            end
            if (en_cnt < W) begin
                chk(poke ? "R7" : "R3", "busy mid-run", busy, 1);
                chk(poke ? "R7" : "R3", "done mid-run", done, 0);
            end
        end
        shift_en = 0; start = 0; load = 0;
        chk("R3", "done at end", done, 1);
        chk("R3", "busy at end", busy, 0);
        chk(poke ? "R8" : "R3", "sum", sum_out, exp[W-1:0]);
        chk(poke ? "R8" : "R3", "carry", carry_out, exp[W]);
        @(negedge clk);
        chk("R3", "done one cycle", done, 0);
        m_a = exp[W-1:0];
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
    end

    initial begin
        void'($urandom(32'd1234));
        rst = 1; load = 0; start = 0; shift_en = 0; a_in = '0; b_in = '0;
        m_a = '0; m_b = '0;
        repeat (3) @(negedge clk);
        rst = 0;
        chk("R1", "sum_out reset", sum_out, 0);
        chk("R1", "carry reset", carry_out, 0);
        chk("R1", "busy reset", busy, 0);
        chk("R1", "done reset", done, 0);

        // R9: shift_en while idle does nothing
        do_add(4'd9, 4'd3, 1, 0, 0);
        shift_en = 1;
        repeat (3) begin
            @(negedge clk);
            chk("R9", "sum idle shift", sum_out, 4'd12);
            chk("R9", "carry idle shift", carry_out, 0);
            chk("R9", "done idle shift", done, 0);
        end
        shift_en = 0;

        // Directed corners: overflow then chained adds (R4, R5)
        do_add(4'hF, 4'hF, 1, 0, 0);   // 30: sum 14, carry 1
        do_add('0, '0, 0, 0, 0);       // R4: 14+15 = 29 -> 13, carry 1
        chk("R4", "chained sum", sum_out, 4'd13);
        do_add('0, '0, 0, 30, 0);      // R4: 13+15 = 28 -> 12
        chk("R4", "chained sum 2", sum_out, 4'd12);
        do_add(4'd0, 4'd1, 1, 0, 0);   // R5: stale carry must not appear
        chk("R5", "no stale carry", sum_out, 4'd1);

        // R7/R8: pokes during run
        do_add(4'd6, 4'd7, 1, 40, 1);
        do_add(4'hA, 4'h5, 1, 20, 1);

        // Exhaustive operand pairs with random stalls
        for (int a = 0; a < (1 << W); a++)
            for (int b = 0; b < (1 << W); b++)
                do_add(W'(a), W'(b), 1, 25, 0);

        // Random chained sequences
        for (int i = 0; i < 100; i++)
            do_add(W'($urandom), W'($urandom), ($urandom % 2) == 0, 50, ($urandom % 4) == 0);

        summary();
    end
endmodule